// File: doc/BRIEF.md
# Configurable Audio Serial Transmitter

This block turns 32-bit words taken from a transmit FIFO read port into an I2S serial data stream. In master mode it divides a clock-enable pulse train (`bit_tick`) into a bit clock and a word-select line. The word-select half period is set in bit clocks, independently of the sample size. In slave mode it follows a bit clock and word select driven from outside, and the half-period setting has no effect.

Each channel slot starts at a word-select transition. The block takes the low 8, 16, 24 or 32 bits of a FIFO word and shifts them out most significant bit first. The first bit appears one bit clock after the transition, and any positions left in the slot carry zeros.

Several control inputs shape the stream:
- Mono sends one FIFO word in both slots of a frame.
- Mute silences the data line while the FIFO keeps draining.
- Stop silences the line and makes no FIFO reads.
- A level-sensitive soft reset clears the channel at once, without waiting for a clock edge, and asks the FIFO to empty itself.

Top module: `aud_ser_tx`

## Requirements
- R1: While `rst` is high, `sd_o` is 0, `ws_o` is 1, `bclk_o` is 0, `fifo_pop` is 0 and `underrun` is 0. `clk_oe` is 1 exactly when `cfg_slave` is 0.
- R2: In master mode `bclk_o` toggles on every `bit_tick` pulse. `ws_o` flips once every `cfg_half`+1 bit-clock periods. `ws_o` and `sd_o` change only on a falling edge of `bclk_o`, except when mute or stop changes.
- R3: The most significant sample bit appears on the first falling bit-clock edge after the word-select transition. Bits follow in descending order. The first slot after reset or soft reset is the left slot, marked by `ws_o` = 0; `ws_o` = 1 marks the right slot.
- R4: `cfg_size` code c gives a sample of 8*(c+1) bits, taken from the low bits of the FIFO word. Slot positions after the last sample bit carry 0.
- R5: With mono clear, each slot start pops one FIFO word, so the left and right slots carry successive words.
- R6: With mono set, a word is popped only when a left slot starts, and the same sample is sent in the following right slot.
- R7: While `cfg_mute` is 1, `sd_o` is 0 and FIFO words are still popped at slot starts.
- R8: While `cfg_stop` is 1, `sd_o` is 0, no word is popped and no underrun is recorded.
- R9: When a slot needs a word and `fifo_empty` is 1, the slot sends zeros and `underrun` goes to 1. It stays 1 until `rst` or `cfg_srst`.
- R10: `cfg_srst` high clears the channel state, including `underrun`, without waiting for a clock edge. `fifo_clr` follows `cfg_srst`.
- R11: With `cfg_slave` = 1, `clk_oe` is 0, slots follow the falling edges of `bclk_i` and the value of `ws_i`, and `cfg_half` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_srst | input | 1 | Soft reset of the channel, asynchronous, active high |
| cfg_slave | input | 1 | 1 = follow external bit clock and word select |
| cfg_size | input | 2 | Sample size code, 8*(code+1) bits |
| cfg_mono | input | 1 | 1 = one word feeds both slots |
| cfg_stop | input | 1 | 1 = no FIFO reads, line silent |
| cfg_mute | input | 1 | 1 = line silent, reads continue |
| cfg_half | input | 9 | Bit clocks per word-select half, minus one |
| bit_tick | input | 1 | Bit-clock edge enable (master mode) |
| bclk_i | input | 1 | External bit clock (slave mode) |
| ws_i | input | 1 | External word select (slave mode) |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_rdata | input | 32 | FIFO head word, valid while not empty |
| fifo_pop | output | 1 | Consume FIFO head at this clock edge |
| fifo_clr | output | 1 | Request to empty the FIFO |
| bclk_o | output | 1 | Generated bit clock |
| ws_o | output | 1 | Word select, 0 = left |
| clk_oe | output | 1 | Drive enable for bit clock and word select pins |
| sd_o | output | 1 | Serial data |
| underrun | output | 1 | Sticky flag for a slot that found the FIFO empty |

## Verification
The checker watches these properties on every cycle:
- no pop is issued against an empty FIFO;
- no pop is issued while stopped;
- the data line stays low when muted or stopped;
- in master mode, word select and data move only on bit-clock falling edges;
- a mono pop always opens a left slot;
- the underrun flag holds once set.

Some behaviour only the bench scenarios can show. A receiver model in the bench rebuilds each slot from the line, which shows the sample values, bit order, zero padding and slot lengths for each size and half period. The scenarios also show the mono and mute word counts, the slave mode that follows bench-driven clocks, and the soft reset acting between clock edges.

// File: rtl/aud_tx_pkg.sv
`timescale 1ns/1ps
package aud_tx_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 9;
    localparam int SZ_W   = 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    // Per-clock timing event produced by the clock generator.
    typedef struct packed {
        logic  fall;   // bit-clock falling edge in this cycle
        logic  start;  // falling edge that opens a new slot
        chan_e ws;     // word-select value after this edge
    } edge_ev_t;

    function automatic int sample_bits(input logic [SZ_W-1:0] code);
        return 8 * (int'(code) + 1);
    endfunction

    // Move the low sample bits of a FIFO word to the top of the shifter.
    function automatic word_t left_align(input word_t w, input logic [SZ_W-1:0] code);
        return w << (WORD_W - sample_bits(code));
    endfunction

endpackage

// File: rtl/aud_tx_clkgen.sv
`timescale 1ns/1ps
module aud_tx_clkgen
    import aud_tx_pkg::*;
#(
    parameter int HW = HALF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          srst,
    input  logic          slave,
    input  logic [HW-1:0] half,
    input  logic          bit_tick,
    input  logic          bclk_i,
    input  logic          ws_i,
    output logic          bclk_o,
    output logic          ws_o,
    output edge_ev_t      ev
);

    logic          bclk_q;
    logic          bclk_in_q;
    chan_e         ws_q;
    logic [HW-1:0] cnt;
    logic          fall;
    logic          wrap;
    chan_e         ws_nxt;

    assign wrap   = (cnt >= half);
    assign fall   = slave ? (bclk_in_q & ~bclk_i) : (bit_tick & bclk_q);
    assign ws_nxt = slave ? chan_e'(ws_i) : (wrap ? chan_e'(~ws_q) : ws_q);

    always_comb begin
        ev.fall  = fall;
        ev.ws    = ws_nxt;
        ev.start = fall && (ws_nxt != ws_q);
    end

    always_ff @(posedge clk or posedge srst) begin
        if (srst) begin
            bclk_q    <= 1'b0;
            bclk_in_q <= 1'b0;
            ws_q      <= CH_RIGHT;
            cnt       <= '1;
        end else if (rst) begin
            bclk_q    <= 1'b0;
            bclk_in_q <= 1'b0;
            ws_q      <= CH_RIGHT;
            cnt       <= '1;
        end else begin
            bclk_in_q <= bclk_i;
            if (!slave && bit_tick)
                bclk_q <= ~bclk_q;
            if (fall) begin
                ws_q <= ws_nxt;
                cnt  <= (slave || wrap) ? '0 : cnt + 1'b1;
            end
        end
    end

    assign bclk_o = bclk_q;
    assign ws_o   = ws_q;

endmodule

// File: rtl/aud_tx_slot.sv
`timescale 1ns/1ps
module aud_tx_slot
    import aud_tx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            srst,
    input  edge_ev_t        ev,
    input  logic            mono,
    input  logic            stop,
    input  logic [SZ_W-1:0] size,
    input  logic            fifo_empty,
    input  word_t           fifo_rdata,
    output logic            fifo_pop,
    output word_t           load_val,
    output logic            underrun
);

    logic  need_word;
    logic  reuse;
    word_t fresh;
    word_t hold;
    logic  urun_q;

    assign reuse     = mono && (ev.ws == CH_RIGHT);
    assign need_word = ev.start && !stop && !reuse;
    assign fifo_pop  = need_word && !fifo_empty;
    assign fresh     = fifo_empty ? '0 : left_align(fifo_rdata, size);

    always_comb begin
        if (stop)
            load_val = '0;
        else if (reuse)
            load_val = hold;
        else
            load_val = fresh;
    end

    always_ff @(posedge clk or posedge srst) begin
        if (srst) begin
            hold   <= '0;
            urun_q <= 1'b0;
        end else if (rst) begin
            hold   <= '0;
            urun_q <= 1'b0;
        end else if (need_word) begin
            hold <= fresh;
            if (fifo_empty)
                urun_q <= 1'b1;
        end
    end

    assign underrun = urun_q;

endmodule

// File: rtl/aud_tx_shift.sv
`timescale 1ns/1ps
module aud_tx_shift
    import aud_tx_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         srst,
    input  edge_ev_t     ev,
    input  logic [W-1:0] load_val,
    output logic         sd_q
);

    logic [W-1:0] sh;

    // The bit leaving the top goes out on this falling edge. A new sample
    // is loaded behind it, so its MSB appears one bit clock later.
    always_ff @(posedge clk or posedge srst) begin
        if (srst) begin
            sh   <= '0;
            sd_q <= 1'b0;
        end else if (rst) begin
            sh   <= '0;
            sd_q <= 1'b0;
        end else if (ev.fall) begin
            sd_q <= sh[W-1];
            sh   <= ev.start ? load_val : {sh[W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/aud_ser_tx.sv
`timescale 1ns/1ps
module aud_ser_tx
    import aud_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_srst,
    input  logic        cfg_slave,
    input  logic [1:0]  cfg_size,
    input  logic        cfg_mono,
    input  logic        cfg_stop,
    input  logic        cfg_mute,
    input  logic [8:0]  cfg_half,
    input  logic        bit_tick,
    input  logic        bclk_i,
    input  logic        ws_i,
    input  logic        fifo_empty,
    input  logic [31:0] fifo_rdata,
    output logic        fifo_pop,
    output logic        fifo_clr,
    output logic        bclk_o,
    output logic        ws_o,
    output logic        clk_oe,
    output logic        sd_o,
    output logic        underrun
);

    edge_ev_t ev;
    word_t    load_val;
    logic     sd_q;

    aud_tx_clkgen #(.HW(HALF_W)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .srst     (cfg_srst),
        .slave    (cfg_slave),
        .half     (cfg_half),
        .bit_tick (bit_tick),
        .bclk_i   (bclk_i),
        .ws_i     (ws_i),
        .bclk_o   (bclk_o),
        .ws_o     (ws_o),
        .ev       (ev)
    );

    aud_tx_slot u_slot (
        .clk        (clk),
        .rst        (rst),
        .srst       (cfg_srst),
        .ev         (ev),
        .mono       (cfg_mono),
        .stop       (cfg_stop),
        .size       (cfg_size),
        .fifo_empty (fifo_empty),
        .fifo_rdata (fifo_rdata),
        .fifo_pop   (fifo_pop),
        .load_val   (load_val),
        .underrun   (underrun)
    );

    aud_tx_shift #(.W(WORD_W)) u_sh (
        .clk      (clk),
        .rst      (rst),
        .srst     (cfg_srst),
        .ev       (ev),
        .load_val (load_val),
        .sd_q     (sd_q)
    );

    assign sd_o     = sd_q & ~(cfg_mute | cfg_stop);
    assign clk_oe   = ~cfg_slave;
    assign fifo_clr = cfg_srst;

endmodule

// File: rtl/aud_ser_tx_chk.sv
`timescale 1ns/1ps
module aud_ser_tx_chk (
    input logic clk,
    input logic rst,
    input logic cfg_srst,
    input logic cfg_slave,
    input logic cfg_mono,
    input logic cfg_stop,
    input logic cfg_mute,
    input logic fifo_empty,
    input logic fifo_pop,
    input logic bclk_o,
    input logic ws_o,
    input logic sd_o,
    input logic underrun
);

    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst || cfg_srst)
        fifo_pop |-> !fifo_empty);                                          // R9
    AST_STOP_NO_POP: assert property (@(posedge clk) disable iff (rst || cfg_srst)
        cfg_stop |-> !fifo_pop);                                            // R8
    AST_QUIET_LINE: assert property (@(posedge clk) disable iff (rst || cfg_srst)
        (cfg_mute || cfg_stop) |-> !sd_o);                                  // R7
    AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (rst || cfg_srst)
        (!cfg_slave && !$fell(bclk_o)) |-> $stable(ws_o));                  // R2
    AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (rst || cfg_srst)
        (!cfg_slave && !$fell(bclk_o) && $stable(cfg_mute) && $stable(cfg_stop))
        |-> $stable(sd_o));                                                 // R2
    AST_MONO_LEFT_POP: assert property (@(posedge clk) disable iff (rst || cfg_srst)
        (!cfg_slave && cfg_mono && fifo_pop) |=> !ws_o);                    // R6
    AST_URUN_STICKY: assert property (@(posedge clk) disable iff (rst || cfg_srst)
        underrun |=> underrun);                                             // R9

endmodule

bind aud_ser_tx aud_ser_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_srst   (cfg_srst),
    .cfg_slave  (cfg_slave),
    .cfg_mono   (cfg_mono),
    .cfg_stop   (cfg_stop),
    .cfg_mute   (cfg_mute),
    .fifo_empty (fifo_empty),
    .fifo_pop   (fifo_pop),
    .bclk_o     (bclk_o),
    .ws_o       (ws_o),
    .sd_o       (sd_o),
    .underrun   (underrun)
);

// File: tb/sim_aud_ser_tx.sv
`timescale 1ns/1ps
module sim_aud_ser_tx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_srst = 1'b0;
    logic        cfg_slave = 1'b0;
    logic [1:0]  cfg_size = 2'd1;
    logic        cfg_mono = 1'b0;
    logic        cfg_stop = 1'b0;
    logic        cfg_mute = 1'b0;
    logic [8:0]  cfg_half = 9'd31;
    logic        bit_tick = 1'b0;
    logic        bclk_i = 1'b1;
    logic        ws_i = 1'b1;
    logic        fifo_empty;
    logic [31:0] fifo_rdata;
    logic        fifo_pop, fifo_clr, bclk_o, ws_o, clk_oe, sd_o, underrun;

    always #5 clk = ~clk;

    aud_ser_tx u0 (.*);

    int errors = 0;
    int checks = 0;
    logic done = 1'b0;

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // FIFO model: head word presented while not empty, consumed after a pop edge.
    logic [31:0] fq [16];
    int rd = 0, wr = 0, pops = 0;
    logic pend = 1'b0;
    assign fifo_empty = (rd == wr);
    assign fifo_rdata = fq[rd & 15];

    task automatic push(input logic [31:0] w);
        fq[wr & 15] = w;
        wr++;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (pend) begin rd++; pops++; end
            if (fifo_clr) begin rd = 0; wr = 0; end
            #1;
            pend = fifo_pop;
        end
    end

    // Bit clock enable: one pulse every second cycle while enabled.
    logic tick_en = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            bit_tick = tick_en && !bit_tick;
        end
    end

    // Receiver model: rebuilds each slot from the line at bit-clock rises.
    int dec_w = 16;
    int commits = 0, nbits = 0, rises = 0;
    logic [31:0] cur = '0;
    logic [31:0] got [8];
    int got_r [8];
    logic last_ws = 1'b1, prev_b = 1'b0, pad_bad = 1'b0;

    task automatic dec_reset();
        commits = 0; nbits = 0; rises = 0; cur = '0;
        last_ws = 1'b1; prev_b = 1'b0; pad_bad = 1'b0;
    endtask

    task automatic take_bit(input logic b);
        if (nbits < dec_w) begin
            cur = {cur[30:0], b};
            nbits++;
        end else if (b) begin
            pad_bad = 1'b1;
        end
    endtask

    initial begin
        forever begin
            logic b, w;
            @(negedge clk);
            #2;
            b = cfg_slave ? bclk_i : bclk_o;
            w = cfg_slave ? ws_i : ws_o;
            if (b && !prev_b) begin
                take_bit(sd_o);
                if (w != last_ws) begin
                    if (commits < 8) begin
                        got[commits]   = cur;
                        got_r[commits] = rises;
                    end
                    commits++;
                    cur = '0; nbits = 0; rises = 1; last_ws = w;
                end else begin
                    rises++;
                end
            end
            prev_b = b;
        end
    end

    task automatic soft_reset();
        @(negedge clk); cfg_srst = 1'b1;
        @(negedge clk); cfg_srst = 1'b0;
    endtask

    task automatic wait_commits(input int n, input string tag);
        for (int i = 0; i < 6000 && commits < n; i++) @(negedge clk);
        check(commits >= n, tag, commits, n);
    endtask

    typedef struct packed {
        logic [1:0]  sz;
        logic        mono;
        logic        mute;
        logic [8:0]  half;
        logic [31:0] w0;
        logic [31:0] w1;
        logic [31:0] e0;
        logic [31:0] e1;
    } vec_t;

    localparam vec_t VT [8] = '{
        '{2'd1, 1'b0, 1'b0, 9'd15, 32'hA5A51234, 32'h00C3BEEF, 32'h00001234, 32'h0000BEEF},
        '{2'd0, 1'b0, 1'b0, 9'd7,  32'h12345681, 32'h0000007E, 32'h00000081, 32'h0000007E},
        '{2'd3, 1'b0, 1'b0, 9'd31, 32'h80000001, 32'h7FFFFFFE, 32'h80000001, 32'h7FFFFFFE},
        '{2'd2, 1'b0, 1'b0, 9'd40, 32'h12ABCDEF, 32'hFF800001, 32'h00ABCDEF, 32'h00800001},
        '{2'd1, 1'b1, 1'b0, 9'd15, 32'h00005A5A, 32'h00001111, 32'h00005A5A, 32'h00005A5A},
        '{2'd1, 1'b0, 1'b1, 9'd15, 32'h0000FFFF, 32'h0000AAAA, 32'h00000000, 32'h00000000},
        '{2'd0, 1'b1, 1'b0, 9'd20, 32'hFFFFFFC3, 32'h00000055, 32'h000000C3, 32'h000000C3},
        '{2'd3, 1'b0, 1'b0, 9'd63, 32'hDEADBEEF, 32'hCAFEF00D, 32'hDEADBEEF, 32'hCAFEF00D}
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #1500000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", commits, 0);
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(sd_o == 1'b0 && ws_o == 1'b1 && bclk_o == 1'b0, "R1 line idle",
              {29'd0, sd_o, ws_o, bclk_o}, 32'h2);
        check(fifo_pop == 1'b0 && underrun == 1'b0, "R1 no pop no flag",
              {30'd0, fifo_pop, underrun}, 32'h0);
        check(clk_oe == 1'b1, "R1 drive enable master", {31'd0, clk_oe}, 32'h1);
        rst = 1'b0;

        // Table walk: size, mono, mute and half-period variants (R2..R7, R9)
        for (int k = 0; k < 8; k++) begin
            vec_t v;
            v = VT[k];
            tick_en = 1'b0;
            soft_reset();
            cfg_size = v.sz; cfg_mono = v.mono; cfg_mute = v.mute; cfg_half = v.half;
            push(v.w0); push(v.w1);
            dec_w = 8 * (int'(v.sz) + 1);
            dec_reset();
            pops = 0;
            tick_en = 1'b1;
            wait_commits(3, "R3 slots reached");
            tick_en = 1'b0;
            check(got[1] == v.e0, "R3 R4 R6 R7 left slot", got[1], v.e0);
            check(got[2] == v.e1, "R3 R4 R5 R6 right slot", got[2], v.e1);
            check(got_r[1] == int'(v.half) + 1, "R2 half length", got_r[1], int'(v.half) + 1);
            check(pad_bad == 1'b0, "R4 zero padding", {31'd0, pad_bad}, 32'h0);
            check(pops == 2, "R5 R6 R7 words taken", pops, 2);
            check(underrun == !v.mono, "R9 underrun flag", {31'd0, underrun}, {31'd0, !v.mono});
        end

        // R10: soft reset acts between clock edges
        @(negedge clk);
        check(underrun == 1'b1, "R10 flag before soft reset", {31'd0, underrun}, 32'h1);
        #1 cfg_srst = 1'b1;
        #1;
        check(underrun == 1'b0 && fifo_clr == 1'b1, "R10 async clear",
              {30'd0, underrun, fifo_clr}, 32'h1);
        @(negedge clk); cfg_srst = 1'b0;

        // R8: stop mode with words waiting
        cfg_mono = 1'b0; cfg_mute = 1'b0; cfg_size = 2'd1; cfg_half = 9'd7; cfg_stop = 1'b1;
        push(32'h0000FFFF); push(32'h0000F0F0);
        dec_w = 16; dec_reset(); pops = 0;
        tick_en = 1'b1;
        wait_commits(3, "R8 slots reached");
        tick_en = 1'b0;
        check(got[1] == 32'h0 && got[2] == 32'h0, "R8 silent line", got[1] | got[2], 32'h0);
        check(pops == 0 && (wr - rd) == 2, "R8 no reads", pops, 0);
        check(underrun == 1'b0, "R8 no underrun", {31'd0, underrun}, 32'h0);
        cfg_stop = 1'b0;

        // R11: slave mode follows bench-driven clocks, half setting ignored
        @(negedge clk); cfg_srst = 1'b1; cfg_slave = 1'b1; bclk_i = 1'b1; ws_i = 1'b1;
        cfg_half = 9'd3;
        @(negedge clk); cfg_srst = 1'b0;
        push(32'hFFFF1357); push(32'h00002468);
        dec_w = 16; dec_reset(); pops = 0;
        check(clk_oe == 1'b0, "R11 pins released", {31'd0, clk_oe}, 32'h0);
        for (int h = 0; h < 3; h++) begin
            for (int b = 0; b < 16; b++) begin
                @(negedge clk); bclk_i = 1'b0;
                if (b == 0) ws_i = h[0];
                @(negedge clk);
                @(negedge clk); bclk_i = 1'b1;
                @(negedge clk);
            end
        end
        repeat (2) @(negedge clk);
        check(commits >= 3, "R11 slots reached", commits, 3);
        check(got[1] == 32'h00001357, "R11 slave left", got[1], 32'h00001357);
        check(got[2] == 32'h00002468, "R11 slave right", got[2], 32'h00002468);
        check(got_r[1] == 16, "R11 slave length", got_r[1], 16);
        check(underrun == 1'b1, "R9 slave third slot empty", {31'd0, underrun}, 32'h1);

        finish_run();
    end

endmodule